// File: doc/BRIEF.md
# Multi-Lane Pixel Word Serializer

This block turns one parallel pixel word per pixel-clock period into a serial stream. The word holds 24 colour bits and 3 control bits. It is captured on each rising edge of the pixel clock. The block then appends an odd-parity bit and two zero padding bits, which gives a 30-bit frame. That frame is shifted out, most significant bit first, on one, two or three serial lanes, with the bits dealt round-robin across the active lanes. A fast bit clock, supplied from outside, runs at the lane bit rate: 30, 15 or 10 times the pixel rate. The block rebuilds the pixel clock from that fast clock and drives it on a forwarded-clock output, so a receiver can find the frame boundaries.

A small power controller exposes the current power mode so the surrounding analog circuits can be gated. The modes are:

- **Shutdown**: entered whenever transmit-enable is low.
- **Standby**: entered on its own when the pixel clock stops.
- **Active**: entered on the next pixel edge while transmit-enable is high.

The block makes these assumptions:

- Transmit-enable is synchronous to the fast clock.
- The captured word crosses into the fast domain only while it is stable, because at least 10 fast cycles pass between pixel edges.

Top module: `pxl_lane_serializer`

## Requirements
- R1: The data and control inputs are sampled only on the rising pixel-clock edge. Changes between two rising edges do not alter the frame that is sent.
- R2: Frame layout, bit 29 first: bits 29..6 carry the colour word (bit 29 = colour bit 23), bits 5..3 carry the control bits (bit 5 = control bit 2), bit 2 is parity, and bits 1..0 are always 0.
- R3: The parity bit makes the total number of ones over the 27 payload bits plus the parity bit odd.
- R4: Lane count L is set by link_sel: 00 gives 1 lane, 01 gives 2, 10 gives 3, and 11 gives 3. Each lane sends 30/L bits per pixel. In slot j, lane k carries frame bit 29-(j*L+k).
- R5: Lanes with index L or above stay low for the whole frame.
- R6: fwd_clk is high during the first floor(30/L/2) slots of each frame and low during the rest. It rises only in the cycle after a frame load.
- R7: pwr_mode encoding: 00 is shutdown, 01 is standby, 10 is active, and 11 never appears. Reset gives standby. Outside active mode, all lanes and fwd_clk are low.
- R8: If no new pixel edge arrives, active mode drops to standby exactly 64 fast cycles after the last frame load.
- R9: From standby, the next pixel edge (with tx_en high) returns the block to active, and frames resume correctly.
- R10: With tx_en low, the block is in shutdown from the next fast edge on and ignores pixel edges. Raising tx_en moves it to standby first.
- R11: The first slot of a frame appears after the third rising fast-clock edge that follows the rising pixel edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Lane bit clock (30/15/10 x pixel rate) |
| rst_n | input | 1 | Synchronous active-low reset, fast domain |
| pix_clk | input | 1 | Pixel clock; rising edge captures the word |
| pix_data | input | 24 | Colour bits of the pixel word |
| ctl_bits | input | 3 | Control bits of the pixel word |
| link_sel | input | 2 | Lane-count select |
| tx_en | input | 1 | Transmit enable; low forces shutdown |
| lane_out | output | 3 | Serial data lanes |
| fwd_clk | output | 1 | Regenerated pixel clock |
| pwr_mode | output | 2 | Current power mode |

## Verification
The bench builds the block with its default parameters: 24 colour bits, 3 control bits, 3 lanes and a 64-cycle loss window. At these sizes, every lane select code can be swept against every single-bit payload pattern, plus all-zero, all-one and pseudo-random words. Every frame is checked whole for layout, parity, lane distribution, clock shape and latency. The 64-cycle window is short enough that the exact standby entry cycle, the resume path and the shutdown gate are each probed at their boundary cycles.

// File: rtl/pxs_pkg.sv
// Shared types for the pixel word serializer.
// Assumes a two-bit power mode field that the surrounding power logic decodes.
package pxs_pkg;

    typedef enum logic [1:0] {
        PM_SHUTDOWN = 2'b00,
        PM_STANDBY  = 2'b01,
        PM_ACTIVE   = 2'b10
    } pwr_mode_e;

    // Number of slots needed to send a frame of frame_w bits over l lanes.
    function automatic int unsigned slots_per_frame(int unsigned frame_w, int unsigned l);
        return (frame_w + l - 1) / l;
    endfunction

endpackage

// File: rtl/pxs_frame_capture.sv
// Captures the parallel pixel word on the rising pixel-clock edge and forms
// the serial frame {colour, control, parity, reserved zeros}.
// Assumes: the captured register is a pure datapath (no reset needed). The
// fast domain reads it only while it is stable, at least 10 fast cycles
// after a pixel edge.
module pxs_frame_capture #(
    parameter int PIX_W = 24,
    parameter int CTL_W = 3,
    parameter int RSV_W = 2,
    localparam int PAY_W   = PIX_W + CTL_W,
    localparam int FRAME_W = PAY_W + 1 + RSV_W
) (
    input  logic               pix_clk,
    input  logic [PIX_W-1:0]   pix_data,
    input  logic [CTL_W-1:0]   ctl_bits,
    output logic [FRAME_W-1:0] frame
);

    logic [PAY_W-1:0] payload_q;
    logic             parity_bit;

    // Latch colour and control bits on every rising pixel edge.
    always_ff @(posedge pix_clk) begin
        payload_q <= {pix_data, ctl_bits};
    end

    // Odd parity: the parity bit makes the count of ones over payload plus parity odd.
    always_comb begin
        parity_bit = ~(^payload_q);
    end

    // Assemble the frame, most significant bit sent first.
    always_comb begin
        frame = {payload_q, parity_bit, {RSV_W{1'b0}}};
    end

endmodule

// File: rtl/pxs_clk_monitor.sv
// Brings the pixel clock into the fast domain, flags each rising pixel edge,
// and reports the clock as lost once IDLE_LIM fast cycles pass without an edge.
// Assumes: pix_clk is much slower than fast_clk (at least 10 fast cycles per period).
module pxs_clk_monitor #(
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_LIM    = 64,
    localparam int CNT_W = $clog2(IDLE_LIM)
) (
    input  logic fast_clk,
    input  logic rst_n,
    input  logic pix_clk,
    output logic pix_edge,
    output logic pix_lost
);

    logic [SYNC_STAGES:0] chain_q;
    logic [CNT_W-1:0]     idle_q;

    // Synchronizer chain plus one history stage for edge detection.
    always_ff @(posedge fast_clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-1:0], pix_clk};
        end
    end

    // Rising edge seen after the synchronizer.
    always_comb begin
        pix_edge = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
    end

    // Count fast cycles since the last pixel edge, saturating at the limit.
    always_ff @(posedge fast_clk) begin
        if (!rst_n) begin
            idle_q <= CNT_W'(IDLE_LIM - 1);
        end else if (pix_edge) begin
            idle_q <= '0;
        end else if (idle_q != CNT_W'(IDLE_LIM - 1)) begin
            idle_q <= idle_q + 1'b1;
        end
    end

    // The clock counts as lost when the window has run out with no edge this cycle.
    always_comb begin
        pix_lost = (idle_q == CNT_W'(IDLE_LIM - 1)) && !pix_edge;
    end

endmodule

// File: rtl/pxs_power_ctrl.sv
// Power-mode sequencer: shutdown under transmit-enable, standby on pixel clock
// loss, active on a pixel edge. It issues the frame-load and clear strobes.
// Assumes: tx_en is synchronous to fast_clk.
module pxs_power_ctrl
    import pxs_pkg::*;
(
    input  logic      fast_clk,
    input  logic      rst_n,
    input  logic      tx_en,
    input  logic      pix_edge,
    input  logic      pix_lost,
    output pwr_mode_e mode,
    output logic      load,
    output logic      clear
);

    pwr_mode_e mode_q, mode_d;

    // Next-mode decision; transmit-enable has highest priority.
    always_comb begin
        mode_d = mode_q;
        case (mode_q)
            PM_SHUTDOWN: if (tx_en) mode_d = PM_STANDBY;
            PM_STANDBY: begin
                if (!tx_en)        mode_d = PM_SHUTDOWN;
                else if (pix_edge) mode_d = PM_ACTIVE;
            end
            PM_ACTIVE: begin
                if (!tx_en)        mode_d = PM_SHUTDOWN;
                else if (pix_edge) mode_d = PM_ACTIVE;
                else if (pix_lost) mode_d = PM_STANDBY;
            end
            default: mode_d = PM_STANDBY;
        endcase
    end

    // Mode register.
    always_ff @(posedge fast_clk) begin
        if (!rst_n) begin
            mode_q <= PM_STANDBY;
        end else begin
            mode_q <= mode_d;
        end
    end

    // Load a new frame on each accepted pixel edge; clear the lanes when leaving active.
    always_comb begin
        load  = tx_en && pix_edge && (mode_q != PM_SHUTDOWN);
        clear = (mode_d != PM_ACTIVE);
        mode  = mode_q;
    end

endmodule

// File: rtl/pxs_lane_shifter.sv
// Shifts a loaded frame out over 1..MAX_LANES lanes, L bits per fast cycle,
// and regenerates the pixel clock from the slot counter.
// Assumes: load and clear are never high together.
module pxs_lane_shifter
    import pxs_pkg::*;
#(
    parameter int FRAME_W   = 30,
    parameter int MAX_LANES = 3,
    localparam int LW     = $clog2(MAX_LANES + 1),
    localparam int SLOT_W = $clog2(FRAME_W)
) (
    input  logic                 fast_clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 clear,
    input  logic [FRAME_W-1:0]   frame,
    input  logic [1:0]           link_sel,
    output logic [MAX_LANES-1:0] lane_out,
    output logic                 fwd_clk
);

    logic [FRAME_W-1:0] sr_q;
    logic [SLOT_W-1:0]  slot_q;
    logic [LW-1:0]      lanes_q;
    logic [LW-1:0]      lanes_d;
    logic               busy_q;
    int unsigned        last_slot;
    int unsigned        half_slots;

    // Decode link select: 00 gives one lane, and each step adds one, capped at MAX_LANES.
    always_comb begin
        int unsigned req;
        req     = int'(link_sel) + 1;
        lanes_d = LW'((req > MAX_LANES) ? MAX_LANES : req);
    end

    // Frame length in slots for the latched lane count.
    always_comb begin
        last_slot  = FRAME_W - 1;
        half_slots = FRAME_W / 2;
        for (int l = 1; l <= MAX_LANES; l++) begin
            if (int'(lanes_q) == l) begin
                last_slot  = slots_per_frame(FRAME_W, l) - 1;
                half_slots = slots_per_frame(FRAME_W, l) / 2;
            end
        end
    end

    // Shift register, slot counter and lane-count latch.
    always_ff @(posedge fast_clk) begin
        if (!rst_n) begin
            sr_q    <= '0;
            slot_q  <= '0;
            busy_q  <= 1'b0;
            lanes_q <= LW'(1);
        end else if (clear) begin
            sr_q   <= '0;
            slot_q <= '0;
            busy_q <= 1'b0;
        end else if (load) begin
            sr_q    <= frame;
            slot_q  <= '0;
            busy_q  <= 1'b1;
            lanes_q <= lanes_d;
        end else if (busy_q) begin
            if (int'(slot_q) == last_slot) begin
                busy_q <= 1'b0;
                sr_q   <= '0;
            end else begin
                slot_q <= slot_q + 1'b1;
                sr_q   <= sr_q << lanes_q;
            end
        end
    end

    // Lane k carries the k-th most significant remaining bit; unused lanes stay low.
    for (genvar k = 0; k < MAX_LANES; k++) begin : g_lane
        assign lane_out[k] = busy_q && (k < int'(lanes_q)) && sr_q[FRAME_W-1-k];
    end

    // Regenerated pixel clock: high during the first half of the frame slots.
    always_comb begin
        fwd_clk = busy_q && (int'(slot_q) < half_slots);
    end

endmodule

// File: rtl/pxl_lane_serializer.sv
// Top of the multi-lane pixel word serializer. It ties together capture, clock
// monitoring, power sequencing and lane shifting.
// Assumes: fast_clk runs at the lane bit rate, and tx_en is fast-clock synchronous.
module pxl_lane_serializer
    import pxs_pkg::*;
#(
    parameter int PIX_W       = 24,
    parameter int CTL_W       = 3,
    parameter int RSV_W       = 2,
    parameter int MAX_LANES   = 3,
    parameter int IDLE_LIM    = 64,
    parameter int SYNC_STAGES = 2,
    localparam int FRAME_W = PIX_W + CTL_W + 1 + RSV_W
) (
    input  logic                 fast_clk,
    input  logic                 rst_n,
    input  logic                 pix_clk,
    input  logic [PIX_W-1:0]     pix_data,
    input  logic [CTL_W-1:0]     ctl_bits,
    input  logic [1:0]           link_sel,
    input  logic                 tx_en,
    output logic [MAX_LANES-1:0] lane_out,
    output logic                 fwd_clk,
    output logic [1:0]           pwr_mode
);

    logic [FRAME_W-1:0] frame_w;
    logic               edge_w;
    logic               lost_w;
    logic               load_w;
    logic               clear_w;
    pwr_mode_e          mode_w;

    pxs_frame_capture #(
        .PIX_W(PIX_W),
        .CTL_W(CTL_W),
        .RSV_W(RSV_W)
    ) u_capture (
        .pix_clk (pix_clk),
        .pix_data(pix_data),
        .ctl_bits(ctl_bits),
        .frame   (frame_w)
    );

    pxs_clk_monitor #(
        .SYNC_STAGES(SYNC_STAGES),
        .IDLE_LIM   (IDLE_LIM)
    ) u_monitor (
        .fast_clk(fast_clk),
        .rst_n   (rst_n),
        .pix_clk (pix_clk),
        .pix_edge(edge_w),
        .pix_lost(lost_w)
    );

    pxs_power_ctrl u_power (
        .fast_clk(fast_clk),
        .rst_n   (rst_n),
        .tx_en   (tx_en),
        .pix_edge(edge_w),
        .pix_lost(lost_w),
        .mode    (mode_w),
        .load    (load_w),
        .clear   (clear_w)
    );

    pxs_lane_shifter #(
        .FRAME_W  (FRAME_W),
        .MAX_LANES(MAX_LANES)
    ) u_shifter (
        .fast_clk(fast_clk),
        .rst_n   (rst_n),
        .load    (load_w),
        .clear   (clear_w),
        .frame   (frame_w),
        .link_sel(link_sel),
        .lane_out(lane_out),
        .fwd_clk (fwd_clk)
    );

    // Expose the power mode to drive the analog power gating.
    always_comb begin
        pwr_mode = mode_w;
    end

endmodule

// File: rtl/pxs_serializer_chk.sv
// Assertion checker for pxl_lane_serializer, attached by bind below.
module pxs_serializer_chk #(
    parameter int FRAME_W   = 30,
    parameter int MAX_LANES = 3,
    parameter int IDLE_LIM  = 64,
    localparam int CW = $clog2(IDLE_LIM + 2)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tx_en,
    input logic [1:0]           mode,
    input logic [MAX_LANES-1:0] lane_out,
    input logic                 fwd_clk,
    input logic                 load_i,
    input logic [FRAME_W-1:0]   frame_i
);

    logic [CW-1:0] since_load_q;

    // Count fast cycles since the most recent frame load, saturating above the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_load_q <= CW'(IDLE_LIM + 1);
        end else if (load_i) begin
            since_load_q <= '0;
        end else if (since_load_q != CW'(IDLE_LIM + 1)) begin
            since_load_q <= since_load_q + 1'b1;
        end
    end

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b10) |-> (lane_out == '0 && !fwd_clk));

    // R7
    legal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'b11);

    // R10
    shutdown_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (mode == 2'b00));

    // R8
    standby_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && $past(mode) == 2'b10) |-> (since_load_q == CW'(IDLE_LIM)));

    // R3
    parity_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> ($countones(frame_i) % 2 == 1));

    // R6
    fwd_clk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fwd_clk) |-> $past(load_i));

endmodule

bind pxl_lane_serializer pxs_serializer_chk #(
    .FRAME_W  (FRAME_W),
    .MAX_LANES(MAX_LANES),
    .IDLE_LIM (IDLE_LIM)
) u_chk (
    .clk     (fast_clk),
    .rst_n   (rst_n),
    .tx_en   (tx_en),
    .mode    (pwr_mode),
    .lane_out(lane_out),
    .fwd_clk (fwd_clk),
    .load_i  (load_w),
    .frame_i (frame_w)
);

// File: tb/pxl_lane_serializer_bench.sv
`timescale 1ns/1ps
module pxl_lane_serializer_bench;

    logic        fast_clk = 1'b0;
    logic        rst_n    = 1'b0;
    logic        pix_clk  = 1'b0;
    logic [23:0] pix_data = '0;
    logic [2:0]  ctl_bits = '0;
    logic [1:0]  link_sel = 2'b00;
    logic        tx_en    = 1'b1;
    logic [2:0]  lane_out;
    logic        fwd_clk;
    logic [1:0]  pwr_mode;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int cur_lanes = 1;
    int rise_cyc  = 0;
    logic [26:0] last_word = '0;
    int frames_seen = 0;
    int fs_cyc = 0;

    // Frame-collection state of the monitor.
    logic        collecting = 1'b0;
    logic        prev_fwd   = 1'b0;
    int          slot_j = 0;
    int          mon_l  = 1;
    int          mon_n  = 30;
    int          highs  = 0;
    logic        unused_bad = 1'b0;
    logic [29:0] got = '0;
    logic [29:0] expf = '0;

    pxl_lane_serializer u_pxl_lane_serializer (
        .fast_clk(fast_clk), .rst_n(rst_n), .pix_clk(pix_clk),
        .pix_data(pix_data), .ctl_bits(ctl_bits), .link_sel(link_sel),
        .tx_en(tx_en), .lane_out(lane_out), .fwd_clk(fwd_clk), .pwr_mode(pwr_mode)
    );

    always #10 fast_clk = ~fast_clk;

    always @(posedge fast_clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [29:0] exp_frame(input logic [26:0] w);
        return {w, ~(^w), 2'b00};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge fast_clk);
    endtask

    // One pixel period of 30/L fast cycles. Data is corrupted after the rising edge (R1).
    task automatic send_pixel(input logic [26:0] w);
        int n;
        n = 30 / cur_lanes;
        pix_data  = w[26:3];
        ctl_bits  = w[2:0];
        pix_clk   = 1'b1;
        rise_cyc  = cyc;
        last_word = w;
        tick(2);
        pix_data = ~w[26:3];
        ctl_bits = ~w[2:0];
        tick(n / 2 - 2);
        pix_clk = 1'b0;
        tick(n - n / 2);
    endtask

    // Monitor: reassemble each frame from the lanes and check it.
    always @(negedge fast_clk) begin
        if (rst_n && !collecting && fwd_clk && !prev_fwd) begin
            collecting = 1'b1;
            slot_j = 0;
            mon_l  = cur_lanes;
            mon_n  = 30 / cur_lanes;
            highs  = 0;
            unused_bad = 1'b0;
            got    = '0;
            expf   = exp_frame(last_word);
            fs_cyc = cyc;
            check(cyc - rise_cyc == 3, "R11 frame latency", cyc - rise_cyc, 3);
        end
        if (collecting) begin
            for (int k = 0; k < 3; k++) begin
                if (k < mon_l) got[29 - (slot_j * mon_l + k)] = lane_out[k];
                else if (lane_out[k]) unused_bad = 1'b1;
            end
            if (fwd_clk) highs++;
            slot_j++;
            if (slot_j == mon_n) begin
                collecting = 1'b0;
                frames_seen++;
                check(got[29:3] == expf[29:3], "R1 R4 payload over lanes", got, expf);
                check(got[2] == expf[2], "R3 odd parity", got[2], expf[2]);
                check(got[1:0] == 2'b00, "R2 reserved bits", got[1:0], 0);
                check(!unused_bad, "R5 unused lanes low", unused_bad, 0);
                check(highs == mon_n / 2, "R6 fwd_clk high slots", highs, mon_n / 2);
            end
        end
        prev_fwd = fwd_clk;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge fast_clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [26:0] w;
        int f0;
        tick(5);
        // R7 reset state
        check(pwr_mode == 2'b01, "R7 reset mode", pwr_mode, 1);
        check(lane_out == 3'b000, "R7 reset lanes", lane_out, 0);
        check(fwd_clk == 1'b0, "R7 reset fwd_clk", fwd_clk, 0);
        rst_n = 1'b1;
        tick(3);

        // R4 sweep over all link-select codes and payload patterns.
        for (int ls = 0; ls < 4; ls++) begin
            link_sel  = 2'(ls);
            cur_lanes = (ls == 0) ? 1 : (ls == 1) ? 2 : 3;
            f0 = frames_seen;
            send_pixel(27'h0);
            send_pixel(27'h7FF_FFFF);
            for (int b = 0; b < 27; b++) send_pixel(27'(1) << b);
            w = 27'h1234567;
            for (int r = 0; r < 8; r++) begin
                w = 27'(w * 27'd1103515 + 27'd12345);
                send_pixel(w);
            end
            tick(100);
            check(frames_seen - f0 == 37, "R4 frame count per lane mode", frames_seen - f0, 37);
            check(pwr_mode == 2'b01, "R8 standby after pixel clock stops", pwr_mode, 1);
        end

        // R8 exact standby entry cycle.
        link_sel  = 2'b01;
        cur_lanes = 2;
        send_pixel(27'h5A5A5A5);
        while (cyc < fs_cyc + 63) tick(1);
        check(pwr_mode == 2'b10, "R8 still active at cycle 63", pwr_mode, 2);
        tick(1);
        check(pwr_mode == 2'b01, "R8 standby at cycle 64", pwr_mode, 1);
        check(lane_out == 3'b000 && !fwd_clk, "R8 outputs low in standby", lane_out, 0);

        // R9 resume from standby.
        f0 = frames_seen;
        send_pixel(27'h2AAAAAA);
        check(pwr_mode == 2'b10, "R9 active after resume", pwr_mode, 2);
        send_pixel(27'h1555555);
        send_pixel(27'h00F0F0F);
        tick(20);
        check(frames_seen - f0 == 3, "R9 frames after resume", frames_seen - f0, 3);

        // R10 shutdown gate.
        tx_en = 1'b0;
        tick(1);
        check(pwr_mode == 2'b00, "R10 shutdown entry", pwr_mode, 0);
        f0 = frames_seen;
        for (int p = 0; p < 3; p++) begin
            send_pixel(27'h7FFFFFF);
            check(pwr_mode == 2'b00 && lane_out == 3'b000 && !fwd_clk,
                  "R10 pixel edges ignored in shutdown", {pwr_mode, lane_out}, 0);
        end
        check(frames_seen == f0, "R10 no frames in shutdown", frames_seen - f0, 0);
        tx_en = 1'b1;
        tick(1);
        check(pwr_mode == 2'b01, "R10 standby after enable", pwr_mode, 1);
        send_pixel(27'h3C3C3C3);
        send_pixel(27'h0C0FFEE);
        tick(20);
        check(frames_seen - f0 == 2, "R10 frames after enable", frames_seen - f0, 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule